// File: doc/BRIEF.md
# I2C Controller Status and Wake Logic

This block keeps the status register of an I2C controller. The protocol engines, the interrupt path and the master data buffer report to it through plain level and pulse inputs. It turns those reports into one readable status byte. Two of its flags are sticky and software clears them by writing 1: the interrupt-active flag and the stop-after-error flag. The transfer-pending and transfer-error bits always show the engine's current state. Software cannot write them.

The two buffer-state bits (has data, full) do not follow the buffer at once. Each buffer access starts a settling delay whose length depends on the access width. Until that delay has run out, a read returns the previous buffer state.

A second register address holds the sleep-enable bit. Software sets it to put the controller to sleep and clears it to wake the controller. A Start condition seen on the bus also wakes the controller: it clears the sleep enable and the asleep status bit in hardware. If a Start arrives in the same cycle as a write of 1 to the sleep enable, the Start wins.

Top module: `i2c_stat_wake`

## Requirements
- R1: The synchronous active-low reset clears every status bit and the sleep enable. After the reset, a read at either address returns 0x00.
- R2: Status bit 3 (interrupt active) sets on the edge where `irq_event` and `irq_en` are both 1. It stays set until a status write with bit 3 = 1 clears it. If a set and a clear fall on the same edge, the set wins.
- R3: While `irq_en` is 0, `irq_event` never sets status bit 3.
- R4: Status bit 0 (pending) and bit 1 (error) copy `xfer_pending` and `xfer_err` one edge late. The pair {bit1, bit0} reads 00 for done and clean, 01 for running and clean, 10 for done with data short, and 11 for running with an error.
- R5: Status bit 2 (stop complete) sets on a `stop_err_done` pulse and stays set until a status write with bit 2 = 1 clears it. A set wins over a clear on the same edge.
- R6: Status bit 4 is 1 when the sampled `buf_level` is not zero. Status bit 5 is 1 when the sampled level equals DEPTH. The level is sampled on the 3rd edge after a halfword access (`buf_halfword` = 1) or on the 2nd edge after a byte access.
- R7: Until the delay of R6 has run out, bits 5:4 keep their previous value. A new access restarts the delay, even on the edge where the old delay would have run out.
- R8: A write to address 1 loads bit 0 of the data into the sleep enable. The sleep enable appears on `sleep_o` and in status bit 6 one edge later. Address 1 reads the sleep enable in bit 0, with bits 7:1 reading 0.
- R9: A Start (`start_det` = 1) while asleep clears both `sleep_o` and status bit 6. A Start while awake has no effect.
- R10: A Start on the same edge as a write of 1 to the sleep enable leaves the controller awake.
- R11: A status write does not change bits 0, 1, 4, 5, 6 or 7. Writing 0 to bits 2 and 3 leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 sleep control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_event | input | 1 | Pulse: interrupt raised toward the system interrupt controller |
| irq_en | input | 1 | Interrupt enable control bit |
| xfer_pending | input | 1 | Engine reports a requested transfer pending |
| xfer_err | input | 1 | Engine reports a transfer error |
| stop_err_done | input | 1 | Pulse: a Stop forced by an error has completed |
| buf_access | input | 1 | Pulse: master data buffer was accessed |
| buf_halfword | input | 1 | Width of that access: 1 halfword, 0 byte |
| buf_level | input | 3 | Current fill count of the master data buffer |
| start_det | input | 1 | Pulse: Start condition detected on the bus |
| sleep_o | output | 1 | Sleep enable state |

## Verification
Every flag, the pending/error copy and the sleep state are registered once, so each result is due on the first edge after its stimulus. The buffer bits are due on the 2nd edge (byte access) or the 3rd edge (halfword access) after the access edge. The bench drives inputs at the falling edge and reads at the following falling edges. It checks the buffer bits after every edge of the window, so a result that comes one edge early or late is caught. For each result it also reads once before the due edge, to show the old value is still held.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

    localparam int STAT_W  = 8;

    localparam int B_PEND  = 0;
    localparam int B_ERR   = 1;
    localparam int B_STOP  = 2;
    localparam int B_IRQ   = 3;
    localparam int B_BDAT  = 4;
    localparam int B_BFULL = 5;
    localparam int B_SLP   = 6;

    typedef enum logic [0:0] {
        SEL_STATUS = 1'b0,
        SEL_SLEEP  = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_event,
    input  logic irq_en,
    input  logic stop_err_done,
    input  logic xfer_pending,
    input  logic xfer_err,
    input  logic clr_irq,
    input  logic clr_stop,
    output logic irq_act,
    output logic stop_cmp,
    output logic pend,
    output logic err
);

    typedef struct packed {
        logic irq;
        logic stop;
        logic pend;
        logic err;
    } flags_t;

    flags_t fl_d, fl_q;

    always_comb begin
        fl_d      = fl_q;
        fl_d.pend = xfer_pending;
        fl_d.err  = xfer_err;
        if (clr_irq) begin
            fl_d.irq = 1'b0;
        end
        if (irq_event && irq_en) begin
            fl_d.irq = 1'b1;
        end
        if (clr_stop) begin
            fl_d.stop = 1'b0;
        end
        if (stop_err_done) begin
            fl_d.stop = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign irq_act  = fl_q.irq;
    assign stop_cmp = fl_q.stop;
    assign pend     = fl_q.pend;
    assign err      = fl_q.err;

endmodule

// File: rtl/i2c_stat_bufdly.sv
module i2c_stat_bufdly #(
    parameter int DEPTH    = 4,
    parameter int HW_DLY   = 3,
    parameter int BYTE_DLY = 2,
    localparam int LVL_W   = $clog2(DEPTH + 1),
    localparam int MAX_DLY = (HW_DLY > BYTE_DLY) ? HW_DLY : BYTE_DLY,
    localparam int CNT_W   = $clog2(MAX_DLY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             access,
    input  logic             halfword,
    input  logic [LVL_W-1:0] level,
    output logic             has_data,
    output logic             full
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             has;
        logic             full;
    } bdly_t;

    bdly_t bd_d, bd_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        load_val = halfword ? CNT_W'(HW_DLY) : CNT_W'(BYTE_DLY);
    end

    always_comb begin
        bd_d = bd_q;
        if (access) begin
            bd_d.cnt = load_val;
        end else if (bd_q.cnt != '0) begin
            bd_d.cnt = bd_q.cnt - 1'b1;
            if (bd_q.cnt == CNT_W'(1)) begin
                bd_d.has  = (level != '0);
                bd_d.full = (level == LVL_W'(DEPTH));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bd_q <= '0;
        end else begin
            bd_q <= bd_d;
        end
    end

    assign has_data = bd_q.has;
    assign full     = bd_q.full;

endmodule

// File: rtl/i2c_stat_sleep.sv
module i2c_stat_sleep (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_wr,
    input  logic sleep_val,
    input  logic start_det,
    output logic sleep_en,
    output logic asleep
);

    typedef struct packed {
        logic en;
        logic slp;
    } slp_t;

    slp_t sl_d, sl_q;
    logic wake;

    always_comb begin
        wake = start_det && (sl_q.en || (sleep_wr && sleep_val));
    end

    always_comb begin
        sl_d = sl_q;
        if (sleep_wr) begin
            sl_d.en  = sleep_val;
            sl_d.slp = sleep_val;
        end
        if (wake) begin
            sl_d.en  = 1'b0;
            sl_d.slp = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sl_q <= '0;
        end else begin
            sl_q <= sl_d;
        end
    end

    assign sleep_en = sl_q.en;
    assign asleep   = sl_q.slp;

endmodule

// File: rtl/i2c_stat_wake.sv
module i2c_stat_wake
    import i2c_stat_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int HW_DLY   = 3,
    parameter int BYTE_DLY = 2,
    localparam int LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    input  logic              irq_event,
    input  logic              irq_en,
    input  logic              xfer_pending,
    input  logic              xfer_err,
    input  logic              stop_err_done,
    input  logic              buf_access,
    input  logic              buf_halfword,
    input  logic [LVL_W-1:0]  buf_level,
    input  logic              start_det,
    output logic              sleep_o
);

    logic wr_stat, wr_sleep;
    logic irq_act, stop_cmp, pend, err;
    logic has_data, full, asleep, sleep_en;
    logic [STAT_W-1:0] stat_vec;

    always_comb begin
        wr_stat  = reg_wr && (reg_sel_e'(reg_addr) == SEL_STATUS);
        wr_sleep = reg_wr && (reg_sel_e'(reg_addr) == SEL_SLEEP);
    end

    i2c_stat_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_event     (irq_event),
        .irq_en        (irq_en),
        .stop_err_done (stop_err_done),
        .xfer_pending  (xfer_pending),
        .xfer_err      (xfer_err),
        .clr_irq       (wr_stat && reg_wdata[B_IRQ]),
        .clr_stop      (wr_stat && reg_wdata[B_STOP]),
        .irq_act       (irq_act),
        .stop_cmp      (stop_cmp),
        .pend          (pend),
        .err           (err)
    );

    i2c_stat_bufdly #(
        .DEPTH    (DEPTH),
        .HW_DLY   (HW_DLY),
        .BYTE_DLY (BYTE_DLY)
    ) u_bufdly (
        .clk      (clk),
        .rst_n    (rst_n),
        .access   (buf_access),
        .halfword (buf_halfword),
        .level    (buf_level),
        .has_data (has_data),
        .full     (full)
    );

    i2c_stat_sleep u_sleep (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_wr  (wr_sleep),
        .sleep_val (reg_wdata[0]),
        .start_det (start_det),
        .sleep_en  (sleep_en),
        .asleep    (asleep)
    );

    always_comb begin
        stat_vec          = '0;
        stat_vec[B_PEND]  = pend;
        stat_vec[B_ERR]   = err;
        stat_vec[B_STOP]  = stop_cmp;
        stat_vec[B_IRQ]   = irq_act;
        stat_vec[B_BDAT]  = has_data;
        stat_vec[B_BFULL] = full;
        stat_vec[B_SLP]   = asleep;
    end

    always_comb begin
        if (reg_sel_e'(reg_addr) == SEL_STATUS) begin
            reg_rdata = stat_vec;
        end else begin
            reg_rdata = {{(STAT_W-1){1'b0}}, sleep_en};
        end
    end

    assign sleep_o = sleep_en;

endmodule

// File: rtl/i2c_stat_wake_chk.sv
module i2c_stat_wake_chk
    import i2c_stat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic [STAT_W-1:0] reg_wdata,
    input logic              irq_event,
    input logic              irq_en,
    input logic              xfer_pending,
    input logic              buf_access,
    input logic              start_det,
    input logic              sleep_o,
    input logic [STAT_W-1:0] status
);

    // R2: an enabled interrupt event is reported on the next edge
    p_irq_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_event && irq_en) |=> status[B_IRQ]);

    // R2: write-1 clears the flag when no new event competes
    p_irq_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr && reg_wdata[B_IRQ] && !(irq_event && irq_en))
        |=> !status[B_IRQ]);

    // R3: the flag only rises after an enabled event
    p_irq_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[B_IRQ]) |-> $past(irq_event && irq_en));

    // R4: pending bit copies the engine with one edge of latency
    p_pend_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[B_PEND] == $past(xfer_pending)));

    // R7: an access never changes the buffer bits on its own edge
    p_buf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_access |=> $stable(status[B_BFULL:B_BDAT]));

    // R9: a Start always leaves the block awake
    p_start_wakes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!sleep_o && !status[B_SLP]));

endmodule

bind i2c_stat_wake i2c_stat_wake_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .irq_event    (irq_event),
    .irq_en       (irq_en),
    .xfer_pending (xfer_pending),
    .buf_access   (buf_access),
    .start_det    (start_det),
    .sleep_o      (sleep_o),
    .status       (stat_vec)
);

// File: tb/i2c_stat_wake_test.sv
module i2c_stat_wake_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int HW_D       = 3;
    localparam int BY_D       = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr;
    logic       reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       irq_event, irq_en, xfer_pending, xfer_err, stop_err_done;
    logic       buf_access, buf_halfword, start_det, sleep_o;
    logic [2:0] buf_level;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    // model of expected state
    logic m_pend, m_err, m_stop, m_irq, m_has, m_full, m_slp;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_stat_wake uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .irq_event     (irq_event),
        .irq_en        (irq_en),
        .xfer_pending  (xfer_pending),
        .xfer_err      (xfer_err),
        .stop_err_done (stop_err_done),
        .buf_access    (buf_access),
        .buf_halfword  (buf_halfword),
        .buf_level     (buf_level),
        .start_det     (start_det),
        .sleep_o       (sleep_o)
    );

    function automatic logic [7:0] exp_stat();
        return {1'b0, m_slp, m_full, m_has, m_irq, m_stop, m_err, m_pend};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic chk_stat(input string req);
        logic [7:0] v;
        rd(1'b0, v);
        chk(req, v, exp_stat());
    endtask

    task automatic chk_sleep(input string req);
        logic [7:0] v;
        rd(1'b1, v);
        chk(req, v, {7'b0, m_slp});
        chk(req, {7'b0, sleep_o}, {7'b0, m_slp});
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic buf_acc(input logic hw, input logic [2:0] lvl);
        buf_access = 1'b1; buf_halfword = hw; buf_level = lvl;
        tick();
        buf_access = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = 8'h00;
        irq_event = 1'b0; irq_en = 1'b0; xfer_pending = 1'b0; xfer_err = 1'b0;
        stop_err_done = 1'b0; buf_access = 1'b0; buf_halfword = 1'b0;
        buf_level = 3'd0; start_det = 1'b0;
        {m_pend, m_err, m_stop, m_irq, m_has, m_full, m_slp} = '0;
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;

        // R1 reset state
        chk_stat("R1 status after reset");
        chk_sleep("R1 sleep after reset");

        // R4 all pending/error encodings, one edge latency
        for (int c = 0; c < 4; c++) begin
            xfer_pending = c[0]; xfer_err = c[1];
            chk_stat("R4 before edge");
            tick();
            m_pend = c[0]; m_err = c[1];
            chk_stat("R4 encoding");
        end

        // R2 interrupt set, hold, clear
        irq_en = 1'b1; irq_event = 1'b1;
        tick();
        irq_event = 1'b0; m_irq = 1'b1;
        chk_stat("R2 irq set");
        tick();
        chk_stat("R2 irq held");
        wr(1'b0, 8'h00);
        chk_stat("R11 zero write keeps irq");
        wr(1'b0, 8'h08);
        m_irq = 1'b0;
        chk_stat("R2 irq cleared");
        // R2 set wins over same-edge clear
        irq_event = 1'b1;
        wr(1'b0, 8'h08);
        irq_event = 1'b0; m_irq = 1'b1;
        chk_stat("R2 set beats clear");
        wr(1'b0, 8'h08);
        m_irq = 1'b0;
        // R3 disabled events ignored
        irq_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            irq_event = 1'b1;
            tick();
            irq_event = 1'b0;
            chk_stat("R3 disabled event ignored");
        end

        // R5 stop complete
        stop_err_done = 1'b1;
        tick();
        stop_err_done = 1'b0; m_stop = 1'b1;
        chk_stat("R5 stop set");
        stop_err_done = 1'b1;
        wr(1'b0, 8'h04);
        stop_err_done = 1'b0;
        chk_stat("R5 set beats clear");
        wr(1'b0, 8'h04);
        m_stop = 1'b0;
        chk_stat("R5 stop cleared");

        // R6 sweep every level and both widths
        for (int hw = 0; hw < 2; hw++) begin
            for (int lvl = 0; lvl <= DEPTH; lvl++) begin
                int dly;
                logic n_has, n_full;
                dly    = (hw != 0) ? HW_D : BY_D;
                n_has  = (lvl != 0);
                n_full = (lvl == DEPTH);
                buf_acc(hw[0], 3'(lvl));
                chk_stat("R7 old value after access");
                for (int k = 1; k <= 4; k++) begin
                    tick();
                    if (k >= dly) begin
                        m_has = n_has; m_full = n_full;
                    end
                    chk_stat((k >= dly) ? "R6 buffer bits due" : "R7 buffer bits held");
                end
            end
        end

        // R7 restart exactly on the expiry edge
        buf_acc(1'b0, 3'd0);
        tick(); tick();
        m_has = 1'b0; m_full = 1'b0;
        chk_stat("R7 baseline");
        buf_acc(1'b1, 3'd4);
        tick(); tick();
        chk_stat("R7 before restart");
        buf_acc(1'b0, 3'd1);
        chk_stat("R7 restart suppresses capture");
        tick();
        chk_stat("R7 restarted delay held");
        tick();
        m_has = 1'b1;
        chk_stat("R7 restarted delay due");

        // R8 sleep control
        wr(1'b1, 8'h01);
        m_slp = 1'b1;
        chk_sleep("R8 sleep set");
        chk_stat("R8 asleep status");
        rd(1'b1, v);
        wr(1'b1, 8'hFE);
        m_slp = 1'b0;
        chk_sleep("R8 sleep cleared by bit0");
        chk_stat("R8 asleep status cleared");

        // R9 Start wakes
        wr(1'b1, 8'h01);
        m_slp = 1'b1;
        chk_sleep("R9 asleep before start");
        start_det = 1'b1;
        tick();
        start_det = 1'b0; m_slp = 1'b0;
        chk_sleep("R9 start wakes");
        chk_stat("R9 start clears status");
        start_det = 1'b1;
        tick();
        start_det = 1'b0;
        chk_sleep("R9 start while awake");
        chk_stat("R9 start while awake status");

        // R10 Start beats write of 1
        start_det = 1'b1;
        wr(1'b1, 8'h01);
        start_det = 1'b0;
        chk_sleep("R10 start wins");
        chk_stat("R10 start wins status");

        // R11 status write ignored on read-only bits
        wr(1'b1, 8'h01);
        m_slp = 1'b1;
        xfer_pending = 1'b1; xfer_err = 1'b0;
        tick();
        m_pend = 1'b1; m_err = 1'b0;
        wr(1'b0, 8'hF3);
        chk_stat("R11 read-only bits kept");
        chk_sleep("R11 sleep untouched by status write");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule